// File: doc/BRIEF.md
# Watchdog and Time-Base Divider Chain

This block divides a 32768 Hz reference tick down through one shared binary chain. The chain has a 7-bit divider stage followed by an 8-bit prescaler. Several timing services tap the chain. A watchdog requests a reset when software stops servicing it. A time-base event and a real-time-clock event are one-cycle pulses for the interrupt logic. Two free-running clocks come out for an LCD frame timer and a buzzer. The chain keeps running while the chip is halted. The reference arrives as a one-cycle enable (`ref_tick`) in the fast `clk` domain, and every output is produced in that domain.

The watchdog is two counting stages placed after a chain tap. A clear command zeroes only these two stages, so the phase of the shared chain is kept. An elaboration option sets how servicing works. Either a single clear command is enough, or two distinct commands must both arrive, in either order. What happens on a time-out depends on whether the chip is halted. In run mode the block asks for a full chip reset and records a time-out flag. In halt mode it asks only for a warm restart. A power-down flag records halt entry.

Top module: `wdt_timebase`

## Requirements
- R1: The chain advances only on clock cycles where `ref_tick` is high. While `rst_n` is low, every output is 0, including both flags and both divided clocks.
- R2: `lcd_clk` is bit 2 of the chain count, a square wave of 8 ticks period. `buz_clk` has a period of 2^(2+BUZ_OPT) ticks. With the default option it is bit 1 of the count, high on counts 2 and 3 of every 4.
- R3: `rtc_pulse` is a one-cycle pulse on each rising edge of chain bit 7+`rtc_sel`, giving a period of 2^(8+`rtc_sel`) ticks. With code 0 the first pulse comes 128 ticks after reset.
- R4: `tb_pulse` is a one-cycle pulse with a period of 2^(12+TB_OPT) ticks. With the default option the first pulse comes 2048 ticks after reset and the second 6144 ticks after reset.
- R5: The watchdog times out on the fourth rising edge its two stages count after the last clear. The stages count chain bit 12, or bit 13 when WDT_LONG is set. With no clear, time-outs come 28672 ticks after reset and then every 32768 ticks. In the long variant they come every 65536 ticks.
- R6: A time-out in run mode (`in_halt` low) gives a one-cycle `chip_rst_req`, and `to_flag` is set in that same cycle.
- R7: A time-out while `in_halt` is high gives a one-cycle `warm_rst_req` only. No `chip_rst_req` is raised and `to_flag` is unchanged.
- R8: On the cycle `in_halt` rises, the watchdog stages are zeroed. From the next cycle `pd_flag` is 1 and `to_flag` is 0. This holds even when the watchdog is disabled.
- R9: In single-clear mode, `clr_one` zeroes only the two watchdog stages and clears `to_flag` and `pd_flag`. A clear wins over a time-out in the same cycle. `clr_a` and `clr_b` have no effect.
- R10: In paired-clear mode, a clear happens only once both `clr_a` and `clr_b` have been seen, in either order. The record of seen commands is emptied when the clear happens. `clr_one` has no effect.
- R11: With WDT_ENABLE at 0, no reset request is ever raised and clear commands have no effect, so `pd_flag` stays set after a clear command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| ref_tick | input | 1 | One-cycle enable at the 32768 Hz rate |
| in_halt | input | 1 | High while the chip is in halt mode |
| clr_one | input | 1 | Watchdog clear command, single-clear mode |
| clr_a | input | 1 | First command of the clear pair |
| clr_b | input | 1 | Second command of the clear pair |
| rtc_sel | input | RTC_SEL_W | RTC period code n, period 2^(8+n) ticks |
| chip_rst_req | output | 1 | One-cycle full chip reset request |
| warm_rst_req | output | 1 | One-cycle warm restart request (halt time-out) |
| to_flag | output | 1 | Watchdog time-out flag |
| pd_flag | output | 1 | Power-down flag |
| tb_pulse | output | 1 | Time-base event pulse |
| rtc_pulse | output | 1 | Real-time-clock event pulse |
| lcd_clk | output | 1 | LCD frame clock, reference/8 |
| buz_clk | output | 1 | Buzzer clock |

## Verification
Some properties are checked on every cycle. The divided clocks hold still on cycles without a tick. Both event pulses last one cycle. The two reset requests never coincide. A chip reset request always comes with the time-out flag set. A warm request comes only from halt mode. Halt entry and a single-mode clear leave the flags in the stated states. Some things only the bench scenarios show. These are the exact tick counts of each period and the fact that a clear keeps the chain's phase, so a time-out after a clear lands on a predictable later tap edge. They also include the ordering and forgetting of the paired commands, and the silence of a disabled watchdog.

// File: rtl/wdt_timebase_pkg.sv
package wdt_timebase_pkg;

   typedef enum logic [1:0] {
      WD_NONE = 2'd0,
      WD_CHIP = 2'd1,
      WD_WARM = 2'd2
   } wd_evt_e;

   // chain bit whose rising edge recurs every 2^exp2 ticks
   function automatic int tap_bit(input int exp2);
      return exp2 - 1;
   endfunction

endpackage

// File: rtl/wdt_timebase_cnt.sv
module wdt_timebase_cnt #(
   parameter int WIDTH = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [WIDTH-1:0] cnt,
   output logic [WIDTH-1:0] rise
);
   logic [WIDTH-1:0] carry;

   assign carry[0] = tick;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign rise[b] = carry[b] & ~cnt[b];
      if (b < WIDTH - 1) begin : g_carry
         assign carry[b+1] = carry[b] & cnt[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= cnt + WIDTH'(1);
   end
endmodule

// File: rtl/wdt_timebase_tap.sv
module wdt_timebase_tap #(
   parameter int SEL_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [(1<<SEL_W)-1:0] taps,
   input  logic [SEL_W-1:0]     sel,
   output logic                 pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= taps[sel];
   end
endmodule

// File: rtl/wdt_timebase_wdog.sv
module wdt_timebase_wdog
   import wdt_timebase_pkg::*;
#(
   parameter bit ENABLE = 1'b1,
   parameter bit PAIR   = 1'b0,
   parameter int STG_W  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tap_rise,
   input  logic in_halt,
   input  logic clr_one,
   input  logic clr_a,
   input  logic clr_b,
   output logic chip_req,
   output logic warm_req,
   output logic to_flag,
   output logic pd_flag
);
   logic    clr_hit;
   logic    ovf;
   logic    halt_q;
   logic    halt_entry;
   wd_evt_e evt;

   assign halt_entry = in_halt & ~halt_q;

   if (!ENABLE) begin : g_off
      logic unused_wd;
      assign unused_wd = ^{tap_rise, clr_one, clr_a, clr_b};
      assign clr_hit   = 1'b0;
      assign ovf       = 1'b0;
   end else begin : g_on
      logic [STG_W-1:0] stg;

      if (PAIR) begin : g_pair
         logic seen_a;
         logic seen_b;
         logic unused_one;
         assign unused_one = clr_one;
         assign clr_hit    = (clr_a | seen_a) & (clr_b | seen_b);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seen_a <= 1'b0;
               seen_b <= 1'b0;
            end else if (clr_hit) begin
               seen_a <= 1'b0;
               seen_b <= 1'b0;
            end else begin
               if (clr_a) seen_a <= 1'b1;
               if (clr_b) seen_b <= 1'b1;
            end
         end
      end else begin : g_single
         logic unused_ab;
         assign unused_ab = clr_a ^ clr_b;
         assign clr_hit   = clr_one;
      end

      assign ovf = tap_rise & (&stg) & ~clr_hit & ~halt_entry;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     stg <= '0;
         else if (clr_hit || halt_entry) stg <= '0;
         else if (tap_rise)              stg <= stg + STG_W'(1);
      end
   end

   always_comb begin
      evt = WD_NONE;
      if (ovf) evt = in_halt ? WD_WARM : WD_CHIP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q   <= 1'b0;
         chip_req <= 1'b0;
         warm_req <= 1'b0;
         to_flag  <= 1'b0;
         pd_flag  <= 1'b0;
      end else begin
         halt_q   <= in_halt;
         chip_req <= (evt == WD_CHIP);
         warm_req <= (evt == WD_WARM);
         if (clr_hit) begin
            to_flag <= 1'b0;
            pd_flag <= 1'b0;
         end
         if (evt == WD_CHIP) to_flag <= 1'b1;
         if (halt_entry) begin
            to_flag <= 1'b0;
            pd_flag <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
   import wdt_timebase_pkg::*;
#(
   parameter int DIV_STAGES = 7,
   parameter int PRESC_BITS = 8,
   parameter int RTC_SEL_W  = 3,
   parameter bit WDT_ENABLE = 1'b1,
   parameter bit WDT_LONG   = 1'b0,
   parameter bit CLEAR_PAIR = 1'b0,
   parameter int TB_OPT     = 0,
   parameter int BUZ_OPT    = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ref_tick,
   input  logic                 in_halt,
   input  logic                 clr_one,
   input  logic                 clr_a,
   input  logic                 clr_b,
   input  logic [RTC_SEL_W-1:0] rtc_sel,
   output logic                 chip_rst_req,
   output logic                 warm_rst_req,
   output logic                 to_flag,
   output logic                 pd_flag,
   output logic                 tb_pulse,
   output logic                 rtc_pulse,
   output logic                 lcd_clk,
   output logic                 buz_clk
);
   localparam int CHAIN_W   = DIV_STAGES + PRESC_BITS;
   localparam int WD_STG_W  = 2;
   localparam int WD_TAP    = tap_bit(CHAIN_W - WD_STG_W + (WDT_LONG ? 1 : 0));
   localparam int TB_SEL_W  = 2;
   localparam int TB_SPAN   = 1 << TB_SEL_W;
   localparam int TB_BASE   = tap_bit(CHAIN_W - TB_SEL_W - 1);
   localparam int RTC_SPAN  = 1 << RTC_SEL_W;
   localparam int RTC_BASE  = tap_bit(DIV_STAGES + 1);
   localparam int LCD_BIT   = tap_bit(3);
   localparam int BUZ_BIT   = tap_bit(2 + BUZ_OPT);

   if (TB_OPT < 0 || TB_OPT >= TB_SPAN) begin : g_bad_tb
      $error("TB_OPT out of range");
   end
   if (BUZ_OPT < 0 || BUZ_BIT >= CHAIN_W || BUZ_OPT > 7) begin : g_bad_buz
      $error("BUZ_OPT out of range");
   end
   if (RTC_BASE + RTC_SPAN > CHAIN_W) begin : g_bad_rtc
      $error("RTC select field reaches past the chain");
   end
   if (WD_TAP >= CHAIN_W || TB_BASE < LCD_BIT) begin : g_bad_chain
      $error("chain too short for the watchdog and time-base taps");
   end

   logic [CHAIN_W-1:0] cnt;
   logic [CHAIN_W-1:0] rise;
   logic               unused_chain;

   assign unused_chain = ^{cnt, rise};

   wdt_timebase_cnt #(.WIDTH(CHAIN_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (ref_tick),
      .cnt  (cnt),
      .rise (rise)
   );

   wdt_timebase_tap #(.SEL_W(RTC_SEL_W)) u_rtc (
      .clk  (clk),
      .rst_n(rst_n),
      .taps (rise[RTC_BASE +: RTC_SPAN]),
      .sel  (rtc_sel),
      .pulse(rtc_pulse)
   );

   wdt_timebase_tap #(.SEL_W(TB_SEL_W)) u_tb (
      .clk  (clk),
      .rst_n(rst_n),
      .taps (rise[TB_BASE +: TB_SPAN]),
      .sel  (TB_SEL_W'(TB_OPT)),
      .pulse(tb_pulse)
   );

   wdt_timebase_wdog #(
      .ENABLE(WDT_ENABLE),
      .PAIR  (CLEAR_PAIR),
      .STG_W (WD_STG_W)
   ) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .tap_rise(rise[WD_TAP]),
      .in_halt (in_halt),
      .clr_one (clr_one),
      .clr_a   (clr_a),
      .clr_b   (clr_b),
      .chip_req(chip_rst_req),
      .warm_req(warm_rst_req),
      .to_flag (to_flag),
      .pd_flag (pd_flag)
   );

   assign lcd_clk = cnt[LCD_BIT];
   assign buz_clk = cnt[BUZ_BIT];
endmodule

// File: rtl/wdt_timebase_chk.sv
module wdt_timebase_chk #(
   parameter bit WDT_ENABLE = 1'b1,
   parameter bit CLEAR_PAIR = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic ref_tick,
   input logic in_halt,
   input logic clr_one,
   input logic chip_rst_req,
   input logic warm_rst_req,
   input logic to_flag,
   input logic pd_flag,
   input logic tb_pulse,
   input logic rtc_pulse,
   input logic lcd_clk,
   input logic buz_clk
);
   // R1
   clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ref_tick) |-> ($stable(lcd_clk) && $stable(buz_clk)));

   // R3
   rtc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rtc_pulse |=> !rtc_pulse);

   // R4
   tb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tb_pulse |=> !tb_pulse);

   // R6
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(chip_rst_req && warm_rst_req));

   // R6
   chip_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chip_rst_req |-> to_flag);

   // R7
   warm_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst_req |-> $past(in_halt));

   // R8
   halt_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_halt) |=> (pd_flag && !to_flag));

   if (!WDT_ENABLE) begin : g_off
      // R11
      no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !chip_rst_req && !warm_rst_req);
   end else if (!CLEAR_PAIR) begin : g_single
      // R9
      clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_one && !in_halt) |=> (!to_flag && !pd_flag));
   end
endmodule

bind wdt_timebase wdt_timebase_chk #(
   .WDT_ENABLE(WDT_ENABLE),
   .CLEAR_PAIR(CLEAR_PAIR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ref_tick    (ref_tick),
   .in_halt     (in_halt),
   .clr_one     (clr_one),
   .chip_rst_req(chip_rst_req),
   .warm_rst_req(warm_rst_req),
   .to_flag     (to_flag),
   .pd_flag     (pd_flag),
   .tb_pulse    (tb_pulse),
   .rtc_pulse   (rtc_pulse),
   .lcd_clk     (lcd_clk),
   .buz_clk     (buz_clk)
);

// File: tb/wdt_timebase_test.sv
module wdt_timebase_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   finished = 1'b0;
   bit   d_done = 1'b0;
   bit   n_done = 1'b0;

   always #10 clk = ~clk;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   // default instance: single clear, short period
   logic u_halt = 0, u_one = 0, u_a = 0, u_b = 0;
   logic [2:0] u_sel = 3'd0;
   logic u_chip, u_warm, u_to, u_pd, u_tb, u_rtc, u_lcd, u_buz;

   wdt_timebase uut (
      .clk(clk), .rst_n(rst_n), .ref_tick(tick), .in_halt(u_halt),
      .clr_one(u_one), .clr_a(u_a), .clr_b(u_b), .rtc_sel(u_sel),
      .chip_rst_req(u_chip), .warm_rst_req(u_warm), .to_flag(u_to), .pd_flag(u_pd),
      .tb_pulse(u_tb), .rtc_pulse(u_rtc), .lcd_clk(u_lcd), .buz_clk(u_buz));

   // paired clear, long period
   logic d_halt = 0, d_one = 0, d_a = 0, d_b = 0;
   logic d_chip, d_warm, d_to, d_pd, d_tb, d_rtc, d_lcd, d_buz;

   wdt_timebase #(.WDT_LONG(1'b1), .CLEAR_PAIR(1'b1)) uut_pair (
      .clk(clk), .rst_n(rst_n), .ref_tick(tick), .in_halt(d_halt),
      .clr_one(d_one), .clr_a(d_a), .clr_b(d_b), .rtc_sel(3'd0),
      .chip_rst_req(d_chip), .warm_rst_req(d_warm), .to_flag(d_to), .pd_flag(d_pd),
      .tb_pulse(d_tb), .rtc_pulse(d_rtc), .lcd_clk(d_lcd), .buz_clk(d_buz));

   // watchdog disabled
   logic n_halt = 0, n_one = 0;
   logic n_chip, n_warm, n_to, n_pd, n_tb, n_rtc, n_lcd, n_buz;

   wdt_timebase #(.WDT_ENABLE(1'b0)) uut_off (
      .clk(clk), .rst_n(rst_n), .ref_tick(tick), .in_halt(n_halt),
      .clr_one(n_one), .clr_a(1'b0), .clr_b(1'b0), .rtc_sel(3'd0),
      .chip_rst_req(n_chip), .warm_rst_req(n_warm), .to_flag(n_to), .pd_flag(n_pd),
      .tb_pulse(n_tb), .rtc_pulse(n_rtc), .lcd_clk(n_lcd), .buz_clk(n_buz));

   // event time stamps, sampled between edges
   int u_chip_n = 0, u_warm_n = 0, u_tb_n = 0, d_chip_n = 0, n_req_n = 0;
   int u_chip_t[4];
   int u_warm_t[4];
   int u_tb_t[4];
   int d_chip_t[4];

   always @(negedge clk) if (rst_n) begin
      if (u_chip) begin if (u_chip_n < 4) u_chip_t[u_chip_n] = cyc; u_chip_n++; end
      if (u_warm) begin if (u_warm_n < 4) u_warm_t[u_warm_n] = cyc; u_warm_n++; end
      if (u_tb)   begin if (u_tb_n < 4)   u_tb_t[u_tb_n]     = cyc; u_tb_n++;   end
      if (d_chip) begin if (d_chip_n < 4) d_chip_t[d_chip_n] = cyc; d_chip_n++; end
      if (n_chip || n_warm) n_req_n++;
   end

   // RTC select code and expected period in ticks
   localparam int RTC_VEC [6][2] = '{'{0, 256}, '{1, 512}, '{2, 1024},
                                     '{3, 2048}, '{4, 4096}, '{5, 8192}};

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic wait_rtc(output int t);
      do @(negedge clk); while (!u_rtc);
      t = cyc;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   // paired-clear scenario
   initial begin
      wait (rst_n);
      wait_cyc(17000); d_a = 1; @(negedge clk); d_a = 0;
      wait_cyc(26000); d_b = 1; @(negedge clk); d_b = 0;
      wait_cyc(42000); d_one = 1; @(negedge clk); d_one = 0;
      wait_cyc(89000); check("R10 to before time-out", d_to, 0);
      wait_cyc(91000);
      check("R10 pair count", d_chip_n, 1);
      check("R10 time-out after pair clear", d_chip_t[0], 90112);
      wait_cyc(95000); d_b = 1; @(negedge clk); d_b = 0;
      wait_cyc(99000); check("R10 lone clr_b keeps TO", d_to, 1);
      wait_cyc(100000); d_a = 1; @(negedge clk); d_a = 0;
      wait_cyc(100005); check("R10 reverse pair clears TO", d_to, 0);
      wait_cyc(156000); check("R5 long period time-out", d_chip_t[1], 155648);
      d_done = 1'b1;
   end

   // disabled-watchdog scenario
   initial begin
      wait (rst_n);
      wait_cyc(50000); n_halt = 1;
      wait_cyc(50005); check("R8 PD on halt, watchdog off", n_pd, 1);
      wait_cyc(60000); n_one = 1; @(negedge clk); n_one = 0;
      wait_cyc(60005); check("R11 clear ignored, PD kept", n_pd, 1);
      wait_cyc(156000); check("R11 no reset requests", n_req_n, 0);
      n_done = 1'b1;
   end

   // main scenario
   initial begin
      int t0, t1;
      repeat (3) @(negedge clk);
      check("R1 reset chip", u_chip, 0);
      check("R1 reset TO", u_to, 0);
      check("R1 reset PD", u_pd, 0);
      check("R1 reset clocks", {u_lcd, u_buz, u_tb, u_rtc}, 0);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;

      wait_cyc(2); check("R2 buz at 2", u_buz, 1);
      wait_cyc(3); check("R2 lcd at 3", u_lcd, 0);
      wait_cyc(4); check("R2 lcd at 4", u_lcd, 1);
      check("R2 buz at 4", u_buz, 0);
      wait_cyc(8); check("R2 lcd at 8", u_lcd, 0);

      wait_rtc(t0);
      check("R3 first RTC pulse", t0, 128);
      for (int i = 0; i < 6; i++) begin
         u_sel = 3'(RTC_VEC[i][0]);
         wait_rtc(t0);
         wait_rtc(t1);
         check($sformatf("R3 RTC period code %0d", RTC_VEC[i][0]), t1 - t0, RTC_VEC[i][1]);
      end

      wait_cyc(30000);
      check("R4 first time-base", u_tb_t[0], 2048);
      check("R4 second time-base", u_tb_t[1], 6144);
      check("R5 first time-out", u_chip_t[0], 28672);
      check("R6 TO after run time-out", u_to, 1);
      wait_cyc(61500);
      check("R5 second time-out", u_chip_t[1], 61440);

      wait_cyc(62000); u_one = 1; @(negedge clk); u_one = 0;
      wait_cyc(62005); check("R9 clear drops TO", u_to, 0);
      wait_cyc(80000); u_a = 1; u_b = 1; @(negedge clk); u_a = 0; u_b = 0;
      wait_cyc(95000);
      check("R9 time-out count", u_chip_n, 3);
      check("R9 tail-only clear timing", u_chip_t[2], 94208);

      wait_cyc(104000); u_halt = 1;
      wait_cyc(104005);
      check("R8 PD on halt", u_pd, 1);
      check("R8 TO cleared on halt", u_to, 0);
      wait_cyc(136000);
      check("R7 warm count", u_warm_n, 1);
      check("R7 warm timing", u_warm_t[0], 135168);
      check("R7 no chip request in halt", u_chip_n, 3);
      check("R7 TO unchanged in halt", u_to, 0);
      wait_cyc(137000); u_halt = 0;
      wait_cyc(138000); u_one = 1; @(negedge clk); u_one = 0;
      wait_cyc(138005); check("R9 clear drops PD", u_pd, 0);

      wait (d_done && n_done);
      @(negedge clk);
      tick = 1'b0;
      t0 = {u_lcd, u_buz};
      repeat (40) @(negedge clk);
      check("R1 chain frozen without tick", {u_lcd, u_buz}, t0);
      summary();
   end
endmodule